// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of channels, two by default. Every channel owns a 64-bit counter that runs downward from a programmed interval at a rate set by a 3-bit power-of-two prescaler. When the counter passes zero it raises an event. In periodic mode the counter then takes the interval again. In one-shot mode it halts at zero. All channels share one interrupt-enable word and one interrupt-status word, and they drive a single interrupt line.

Software reaches the block through a plain synchronous port with address, write data, write strobe, read strobe and registered read data, all clocked by the bus clock. Counting takes place in a separate timer clock. Enable and reload commands reach the timer clock through flop synchronizers. Expiry events come back as toggles. The running count is carried to the bus side by a request/acknowledge handshake, so any value that is read is one the counter really held. A channel loaded with all ones in periodic mode serves as a free-running time base whose reading falls steadily.

Top module: `evt_timer_top`

## Requirements
- R1: After reset, every register reads 0 and the interrupt output is low.
- R2: Interrupt enable sits at 0x00 and interrupt status at 0x04, one bit per channel at bit n. Channel n uses a block at base 0x10 + 0x20*n. The control word is at base+0x00, with bit 0 run enable, bit 1 reload strobe, bits 6:4 prescaler select and bit 7 one-shot (1) or periodic (0). The interval low and high words are at base+0x04 and base+0x08 and read back as written.
- R3: The reload strobe bit always reads back as 0.
- R4: In periodic mode with interval N and prescaler select p, expiries repeat every (N+1)*2^p timer-clock cycles.
- R5: In one-shot mode the channel expires exactly once and its count then stays at 0.
- R6: An expiry sets the channel's status bit whatever the enable bit holds. The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new expiry in the same cycle wins over the clear.
- R8: The count (low word at base+0x0C) only ever decrements, apart from loads and periodic reloads. An all-ones periodic channel reads as a falling value.
- R9: After run enable is cleared, the counter advances by at most two more timer cycles and then holds. Setting enable again without reload resumes from the held value.
- R10: Reading the count low word latches the high half. A read of the count high word at base+0x10 returns that latched half, so a low-then-high pair is always coherent.
- R11: A control write with the reload bit loads the interval into the counter and restarts the prescaler. With enable clear the loaded value holds. With enable set, counting starts from it.
- R12: Channels are independent. One channel's expiries set only its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain asynchronous reset, active low |
| tclk | input | 1 | Timer counting clock |
| trst_n | input | 1 | Timer-domain asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, OR of enabled status bits |

## Verification
The hardest case to reach is a read pair that straddles a borrow out of the low count word. There, a fresh high half would no longer match the low half read earlier. The bench loads an interval of 0x1_0000_0030, reads the low word while the high half is still 1, and waits until the counter has borrowed past zero before reading the high word. The combined value must then still lie in the pre-borrow range. A second area is the stop latency across the clock boundary: the bench freezes a running free-run channel and checks that repeated reads agree, then resumes it without a reload.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int DW         = 32;
  localparam int PRE_W      = 7;
  localparam int OFF_IEN    = 'h00;
  localparam int OFF_STS    = 'h04;
  localparam int CH_BASE    = 'h10;
  localparam int CH_STRIDE  = 'h20;
  localparam int SUB_CTRL   = 'h00;
  localparam int SUB_IVL_LO = 'h04;
  localparam int SUB_IVL_HI = 'h08;
  localparam int SUB_CNT_LO = 'h0C;
  localparam int SUB_CNT_HI = 'h10;

  typedef struct packed {
    logic       oneshot;
    logic [2:0] presc;
    logic       en;
  } ctrl_t;

  // byte address of a channel register
  function automatic int ch_addr(input int ch, input int sub);
    return CH_BASE + CH_STRIDE * ch + sub;
  endfunction

  // low p bits set: prescaler window for select p
  function automatic logic [PRE_W-1:0] presc_mask(input logic [2:0] sel);
    logic [7:0] full;
    full = (8'd1 << sel) - 8'd1;
    return full[PRE_W-1:0];
  endfunction

  // a counting step is due when all bits inside the window are set
  function automatic logic tick_due(input logic [PRE_W-1:0] pre, input logic [2:0] sel);
    return (pre & presc_mask(sel)) == presc_mask(sel);
  endfunction

  // read image of the control word; the reload strobe is never stored
  function automatic logic [DW-1:0] ctrl_word(input ctrl_t c);
    return {24'd0, c.oneshot, c.presc, 3'b000, c.en};
  endfunction

endpackage

// File: rtl/evt_bit_sync.sv
module evt_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/evt_chan_core.sv
module evt_chan_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             tclk,
  input  logic             trst_n,
  input  logic             en_s,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] interval,
  input  logic [2:0]       presc,
  input  logic             oneshot,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             exp_tgl
);
  logic [PRE_W-1:0] pre_q;
  logic             armed_q;
  logic             step;

  // interval, presc and oneshot are quasi-static: software changes
  // them only while the channel is stopped or before a reload
  assign step   = en_s && armed_q && !load_evt && tick_due(pre_q, presc);
  assign expire = step && (cnt == '0);

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt     <= '0;
      pre_q   <= '0;
      armed_q <= 1'b0;
      exp_tgl <= 1'b0;
    end else if (load_evt) begin
      cnt     <= interval;
      pre_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (en_s && armed_q) pre_q <= pre_q + 1'b1;
      if (expire) begin
        exp_tgl <= ~exp_tgl;
        if (oneshot) armed_q <= 1'b0;
        else         cnt     <= interval;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_count_xfer.sv
module evt_count_xfer #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         tclk,
  input  logic         trst_n,
  input  logic [W-1:0] src,
  input  logic         bclk,
  input  logic         brst_n,
  output logic [W-1:0] dst
);
  logic         req_b, req_s;
  logic         ack_t, ack_s;
  logic [W-1:0] hold_q;

  evt_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(tclk), .rst_n(trst_n), .d(req_b), .q(req_s));

  // timer side: capture a fresh value when a new request arrives
  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      hold_q <= '0;
      ack_t  <= 1'b0;
    end else if (req_s != ack_t) begin
      hold_q <= src;
      ack_t  <= req_s;
    end
  end

  evt_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(bclk), .rst_n(brst_n), .d(ack_t), .q(ack_s));

  // bus side: hold_q is stable whenever the acknowledge matches
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      dst   <= '0;
      req_b <= 1'b0;
    end else if (ack_s == req_b) begin
      dst   <= hold_q;
      req_b <= ~req_b;
    end
  end
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 64,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              brst_n,
  input  logic              tclk,
  input  logic              trst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int HI_W = CNT_W - DW;

  // bus-domain state
  logic [NUM_CH-1:0]             ien_q;
  logic [NUM_CH-1:0]             sts_q;
  logic [NUM_CH-1:0]             set_evt;
  logic [NUM_CH-1:0][DW-1:0]     ctrl_img_b;
  logic [NUM_CH-1:0][CNT_W-1:0]  ivl_b;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_b;
  logic [NUM_CH-1:0][HI_W-1:0]   snap_b;
  logic [NUM_CH-1:0]             en_b;
  logic [NUM_CH-1:0]             oneshot_b;
  logic [NUM_CH-1:0][2:0]        presc_b;
  logic [NUM_CH-1:0]             ld_tgl_b;
  // timer-domain events
  logic [NUM_CH-1:0]             en_t;
  logic [NUM_CH-1:0]             load_t;
  logic [NUM_CH-1:0]             expire_t;
  logic [NUM_CH-1:0]             exp_tgl_t;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_t;

  logic wr_ien, wr_sts;
  logic [DW-1:0] rd_d;

  assign wr_ien = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_sts = bus_wr && (bus_addr == ADDR_W'(OFF_STS));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ch_addr(i, SUB_CTRL));
    localparam logic [ADDR_W-1:0] A_IVL_LO = ADDR_W'(ch_addr(i, SUB_IVL_LO));
    localparam logic [ADDR_W-1:0] A_IVL_HI = ADDR_W'(ch_addr(i, SUB_IVL_HI));
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(ch_addr(i, SUB_CNT_LO));

    ctrl_t            ctrl_r;
    logic [CNT_W-1:0] ivl_r;
    logic [HI_W-1:0]  snap_r;
    logic             ld_tgl_r;
    logic             ld_s, ld_d;
    logic             exp_s, exp_d;

    always_ff @(posedge bclk or negedge brst_n) begin
      if (!brst_n) begin
        ctrl_r   <= '0;
        ivl_r    <= '0;
        snap_r   <= '0;
        ld_tgl_r <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == A_CTRL) begin
          ctrl_r.en      <= bus_wdata[0];
          ctrl_r.presc   <= bus_wdata[6:4];
          ctrl_r.oneshot <= bus_wdata[7];
          if (bus_wdata[1]) ld_tgl_r <= ~ld_tgl_r;
        end
        if (bus_wr && bus_addr == A_IVL_LO) ivl_r[DW-1:0]    <= bus_wdata;
        if (bus_wr && bus_addr == A_IVL_HI) ivl_r[CNT_W-1:DW] <= bus_wdata[HI_W-1:0];
        if (bus_rd && bus_addr == A_CNT_LO) snap_r <= cnt_b[i][CNT_W-1:DW];
      end
    end

    assign ctrl_img_b[i] = ctrl_word(ctrl_r);
    assign ivl_b[i]      = ivl_r;
    assign snap_b[i]     = snap_r;
    assign en_b[i]       = ctrl_r.en;
    assign presc_b[i]    = ctrl_r.presc;
    assign oneshot_b[i]  = ctrl_r.oneshot;
    assign ld_tgl_b[i]   = ld_tgl_r;

    // commands into the timer clock
    evt_bit_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(tclk), .rst_n(trst_n), .d(en_b[i]), .q(en_t[i]));
    evt_bit_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
      .clk(tclk), .rst_n(trst_n), .d(ld_tgl_b[i]), .q(ld_s));

    always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n) ld_d <= 1'b0;
      else         ld_d <= ld_s;
    end
    assign load_t[i] = ld_s ^ ld_d;

    evt_chan_core #(.CNT_W(CNT_W)) u_core (
      .tclk     (tclk),
      .trst_n   (trst_n),
      .en_s     (en_t[i]),
      .load_evt (load_t[i]),
      .interval (ivl_b[i]),
      .presc    (presc_b[i]),
      .oneshot  (oneshot_b[i]),
      .cnt      (cnt_t[i]),
      .expire   (expire_t[i]),
      .exp_tgl  (exp_tgl_t[i])
    );

    // expiry back into the bus clock
    evt_bit_sync #(.STAGES(SYNC_STAGES)) u_exp_sync (
      .clk(bclk), .rst_n(brst_n), .d(exp_tgl_t[i]), .q(exp_s));

    always_ff @(posedge bclk or negedge brst_n) begin
      if (!brst_n) exp_d <= 1'b0;
      else         exp_d <= exp_s;
    end
    assign set_evt[i] = exp_s ^ exp_d;

    evt_count_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_xfer (
      .tclk   (tclk),
      .trst_n (trst_n),
      .src    (cnt_t[i]),
      .bclk   (bclk),
      .brst_n (brst_n),
      .dst    (cnt_b[i])
    );
  end

  // shared enable and status words
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr_ien) ien_q <= bus_wdata[NUM_CH-1:0];
      sts_q <= (sts_q & ~(wr_sts ? bus_wdata[NUM_CH-1:0] : '0)) | set_evt;
    end
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(OFF_IEN)) rd_d = DW'(ien_q);
    if (bus_addr == ADDR_W'(OFF_STS)) rd_d = DW'(sts_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(ch_addr(i, SUB_CTRL)))   rd_d = ctrl_img_b[i];
      if (bus_addr == ADDR_W'(ch_addr(i, SUB_IVL_LO))) rd_d = ivl_b[i][DW-1:0];
      if (bus_addr == ADDR_W'(ch_addr(i, SUB_IVL_HI))) rd_d = DW'(ivl_b[i][CNT_W-1:DW]);
      if (bus_addr == ADDR_W'(ch_addr(i, SUB_CNT_LO))) rd_d = cnt_b[i][DW-1:0];
      if (bus_addr == ADDR_W'(ch_addr(i, SUB_CNT_HI))) rd_d = DW'(snap_b[i]);
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 8
) (
  input logic                            bclk,
  input logic                            brst_n,
  input logic                            tclk,
  input logic                            trst_n,
  input logic                            irq,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [NUM_CH-1:0]               sts_wd,
  input logic [NUM_CH-1:0]               ien_q,
  input logic [NUM_CH-1:0]               sts_q,
  input logic [NUM_CH-1:0]               set_evt,
  input logic [NUM_CH-1:0]               en_t,
  input logic [NUM_CH-1:0]               load_t,
  input logic [NUM_CH-1:0]               expire_t,
  input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_t
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R9
    stop_hold_chk: assert property (@(posedge tclk) disable iff (!trst_n)
      (!en_t[i] && !load_t[i]) |=> $stable(cnt_t[i]));
    // R8
    down_only_chk: assert property (@(posedge tclk) disable iff (!trst_n)
      !load_t[i] |=> (cnt_t[i] == $past(cnt_t[i]) ||
                      cnt_t[i] == $past(cnt_t[i]) - CNT_W'(1) ||
                      $past(expire_t[i])));
    // R6
    sts_set_chk: assert property (@(posedge bclk) disable iff (!brst_n)
      set_evt[i] |=> sts_q[i]);
    // R6
    sts_cause_chk: assert property (@(posedge bclk) disable iff (!brst_n)
      $rose(sts_q[i]) |-> $past(set_evt[i]));
  end

  // R6
  irq_mask_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (ien_q == '0) |-> !irq);
  // R7
  w1c_all_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (bus_wr && bus_addr == ADDR_W'(4) && (&sts_wd) && set_evt == '0) |=> (sts_q == '0));
  // R7
  w1c_zero_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (bus_wr && bus_addr == ADDR_W'(4) && sts_wd == '0) |=> (($past(sts_q) & ~sts_q) == '0));
endmodule

bind evt_timer_top evt_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .bclk     (bclk),
  .brst_n   (brst_n),
  .tclk     (tclk),
  .trst_n   (trst_n),
  .irq      (irq),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .sts_wd   (bus_wdata[NUM_CH-1:0]),
  .ien_q    (ien_q),
  .sts_q    (sts_q),
  .set_evt  (set_evt),
  .en_t     (en_t),
  .load_t   (load_t),
  .expire_t (expire_t),
  .cnt_t    (cnt_t)
);

// File: tb/evt_timer_tb.sv
module evt_timer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {interval[34:19], prescaler select[18:16], expected period[15:0]}
  localparam logic [34:0] VEC [NV] = '{
    {16'd9,  3'd0, 16'd10},
    {16'd3,  3'd0, 16'd4},
    {16'd4,  3'd1, 16'd10},
    {16'd3,  3'd3, 16'd32},
    {16'd5,  3'd2, 16'd24},
    {16'd20, 3'd0, 16'd21}
  };

  logic bclk = 1'b0, tclk = 1'b0, brst_n = 1'b0, trst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0, bad = 0;

  evt_timer_top dut_i (
    .bclk(bclk), .brst_n(brst_n), .tclk(tclk), .trst_n(trst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) bclk = ~bclk;
  initial begin
    #3;
    forever #(CLK_PERIOD/2) tclk = ~tclk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input logic [63:0] act,
                         input logic [63:0] lo, input logic [63:0] hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s act=%h exp=%h..%h", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge bclk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge bclk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge bclk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge bclk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // watch irq, clearing status bit 0 at each rise
  task automatic watch_irq(input int cycles, output int rises, output int per);
    int t1 = 0, t2 = 0;
    rises = 0;
    for (int c = 1; c <= cycles; c++) begin
      @(negedge bclk);
      bus_wr = 1'b0;
      if (irq) begin
        rises++; t1 = t2; t2 = c;
        bus_addr = 8'h04; bus_wdata = 32'h1; bus_wr = 1'b1;
      end
    end
    @(negedge bclk);
    bus_wr = 1'b0;
    per = t2 - t1;
  endtask

  task automatic stop_clear(input logic [7:0] ctrl_a);
    bwrite(ctrl_a, 32'h0);
    idle(10);
    bwrite(8'h04, 32'h3);
  endtask

  logic [31:0] d, d2;
  logic [63:0] a, b, c;
  int rises, per;

  initial begin
    idle(4);
    brst_n = 1'b1; trst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    bread(8'h00, d); chk("R1 ien", 64'(d), 0);
    bread(8'h04, d); chk("R1 sts", 64'(d), 0);
    bread(8'h10, d); chk("R1 ctrl0", 64'(d), 0);
    bread(8'h14, d); chk("R1 ivl0", 64'(d), 0);
    bread(8'h3C, d); chk("R1 cnt1", 64'(d), 0);

    // R2 map and readback
    bwrite(8'h14, 32'hA5A5_1234);
    bwrite(8'h18, 32'h0000_0077);
    bwrite(8'h10, 32'h0000_00F0);
    bread(8'h10, d); chk("R2 ctrl fields", 64'(d), 64'hF0);
    bread(8'h14, d); chk("R2 ivl lo", 64'(d), 64'hA5A5_1234);
    bread(8'h18, d); chk("R2 ivl hi", 64'(d), 64'h77);
    bwrite(8'h00, 32'h3);
    bread(8'h00, d); chk("R2 ien", 64'(d), 64'h3);
    // R3 reload strobe reads 0
    bwrite(8'h10, 32'h0000_0032);
    bread(8'h10, d); chk("R3 reload reads 0", 64'(d), 64'h30);

    // R11 load with enable clear holds, then enable+reload counts
    bwrite(8'h10, 32'h0);
    bwrite(8'h14, 32'd1234);
    bwrite(8'h18, 32'h0);
    bwrite(8'h10, 32'h2);
    idle(20);
    bread(8'h1C, d); chk("R11 loaded held", 64'(d), 64'd1234);
    idle(30);
    bread(8'h1C, d); chk("R11 still held", 64'(d), 64'd1234);
    bwrite(8'h10, 32'h3);
    idle(30);
    bread(8'h1C, d); chk_rng("R11 counts from interval", 64'(d), 64'd1200, 64'd1222);

    // R4 periodic rate table
    for (int k = 0; k < NV; k++) begin
      stop_clear(8'h10);
      bwrite(8'h14, 32'(VEC[k][34:19]));
      bwrite(8'h18, 32'h0);
      bwrite(8'h10, {24'd0, 1'b0, VEC[k][18:16], 4'b0011});
      watch_irq(400, rises, per);
      chk("R4 period", 64'(per), 64'(VEC[k][15:0]));
    end

    // R5 one-shot
    stop_clear(8'h10);
    bwrite(8'h14, 32'd5);
    bwrite(8'h10, 32'h83);
    watch_irq(200, rises, per);
    chk("R5 single expiry", 64'(rises), 64'd1);
    bread(8'h1C, d); chk("R5 count lo at 0", 64'(d), 0);
    bread(8'h20, d); chk("R5 count hi at 0", 64'(d), 0);

    // R6 status without enable, irq follows enable
    bwrite(8'h00, 32'h0);
    stop_clear(8'h10);
    bwrite(8'h14, 32'd9);
    bwrite(8'h10, 32'h3);
    idle(40);
    chk("R6 masked irq", 64'(irq), 0);
    bread(8'h04, d); chk("R6 status set", 64'(d[0]), 1);
    bwrite(8'h00, 32'h1);
    chk("R6 irq on enable", 64'(irq), 1);
    bwrite(8'h00, 32'h0);
    bwrite(8'h10, 32'h0);
    idle(10);
    // R7 write-one-to-clear
    bwrite(8'h04, 32'h0);
    bread(8'h04, d); chk("R7 zero keeps", 64'(d[0]), 1);
    bwrite(8'h04, 32'h1);
    bread(8'h04, d); chk("R7 one clears", 64'(d[0]), 0);

    // R12 channel independence
    bwrite(8'h34, 32'd7);
    bwrite(8'h38, 32'h0);
    bwrite(8'h30, 32'h3);
    idle(50);
    bread(8'h04, d); chk("R12 only ch1 status", 64'(d), 64'h2);

    // R8 free-running all-ones
    stop_clear(8'h30);
    bwrite(8'h34, 32'hFFFF_FFFF);
    bwrite(8'h38, 32'hFFFF_FFFF);
    bwrite(8'h30, 32'h3);
    idle(20);
    bread(8'h3C, d); a = 64'(d);
    bread(8'h40, d); chk("R8 free-run high", 64'(d), 64'hFFFF_FFFF);
    idle(100);
    bread(8'h3C, d); b = 64'(d);
    chk_rng("R8 falling", a - b, 64'd90, 64'd115);

    // R9 stop and resume
    bwrite(8'h30, 32'h0);
    idle(10);
    bread(8'h3C, d); a = 64'(d);
    idle(50);
    bread(8'h3C, d); b = 64'(d);
    chk("R9 frozen", b, a);
    bwrite(8'h30, 32'h1);
    idle(50);
    bread(8'h3C, d); c = 64'(d);
    chk_rng("R9 resumes", a - c, 64'd35, 64'd60);

    // R10 coherent pair across a borrow
    stop_clear(8'h10);
    bwrite(8'h14, 32'h30);
    bwrite(8'h18, 32'h1);
    bwrite(8'h10, 32'h3);
    idle(25);
    bread(8'h1C, d);
    idle(60);
    bread(8'h20, d2);
    chk_rng("R10 coherent pair", {d2, d}, 64'h1_0000_0000, 64'h1_0000_0030);
    bread(8'h1C, d);
    bread(8'h20, d2);
    chk("R10 high after borrow", 64'(d2), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule